// File: doc/BRIEF.md
# Column Reference-Select Driver

This block prepares one row of binary pixel data for a 1024-column active-matrix array and turns every held bit into a 2-bit reference-select code. The row arrives over sixteen parallel serial lines. Each line fills its own 64-stage shift register, and each register covers 64 neighbouring columns. When a whole row has been shifted in, a load strobe copies all 1024 bits into a holding register. The holding register keeps driving the columns while the next row shifts in behind it.

Each column's code picks one of four analog references outside the block: "on" or "off" for the chosen polarity. The code is built from the column's held bit and a polarity input. Even and odd columns each have their own polarity input. Driving both inputs alike gives whole-frame or row inversion. Driving them in opposite senses gives column inversion, and changing that pattern from row to row gives pixel inversion. Polarity is not latched, so it acts on the outputs at once.

Top module: `col_ref_driver`

## Requirements
- R1: After reset, every shift stage and every holding bit is 0, so each column code carries data bit 0 and shows only its polarity.
- R2: Column index c = s*64 + p. Segment s = 0 is at the left edge of the array. Serial input ser_in[s] enters segment s at position p = 0.
- R3: A shift happens only on a clock edge where shift_en is 1. Each enabled edge moves every bit of a segment one position toward higher p. After 64 enabled edges, the first bit shifted in sits at p = 63. Edges with shift_en at 0 leave the shift contents unchanged.
- R4: On an edge with load at 1, the holding register takes the whole shift register content. The new data appear on col_sel right after that edge. On any edge with load at 0, the holding register does not change.
- R5: While a new row is shifting in and no load occurs, col_sel keeps showing the previously loaded row.
- R6: Column c drives col_sel[2c+1:2c] = {polarity, data}. The codes are: 00 off-positive, 01 on-positive, 10 off-negative, 11 on-negative.
- R7: Even columns take their polarity from pol_even and odd columns from pol_odd. A change of polarity reaches the outputs combinationally, with no load needed.
- R8: When load and shift_en are both 1 on the same edge, the holding register takes the contents as they were before that edge's shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shift_en | input | 1 | Shift enable for all sixteen segments |
| ser_in | input | 16 | One serial data bit per segment |
| load | input | 1 | Copies the shift registers into the holding register |
| pol_even | input | 1 | Negative-polarity select for even columns |
| pol_odd | input | 1 | Negative-polarity select for odd columns |
| col_sel | output | 2048 | Two-bit reference code per column, column c at [2c+1:2c] |

## Verification
The hardest case to reach from the ports is a load strobe on the same edge as a shift. Only here does the order inside the edge show, because the held row must be the pre-shift content. The stimulus makes load and shift_en overlap on purpose and then loads again without shifting, so the one-position offset between the two held rows is exposed. A single marked bit is also walked through one segment for exactly 64 enabled edges, with idle cycles mixed in, to pin the bit order and the column mapping. Random rows with random load points and stalls cover the general mix.

// File: rtl/col_ref_driver_pkg.sv
package col_ref_driver_pkg;

  localparam int unsigned SEG_COUNT_DEF = 16;
  localparam int unsigned SEG_LEN_DEF   = 64;

  typedef enum logic [1:0] {
    REF_OFF_POS = 2'b00,
    REF_ON_POS  = 2'b01,
    REF_OFF_NEG = 2'b10,
    REF_ON_NEG  = 2'b11
  } ref_sel_e;

  function automatic ref_sel_e make_sel(input logic neg, input logic on_bit);
    ref_sel_e r;
    unique case ({neg, on_bit})
      2'b00:   r = REF_OFF_POS;
      2'b01:   r = REF_ON_POS;
      2'b10:   r = REF_OFF_NEG;
      default: r = REF_ON_NEG;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/col_ref_rst_sync.sv
module col_ref_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/col_ref_shift_seg.sv
module col_ref_shift_seg #(
  parameter int unsigned LEN = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           ser_in,
  output logic [LEN-1:0] q
);
  logic [LEN-1:0] q_r;
  logic [LEN-1:0] q_next;

  // Entry at position 0, movement toward higher positions.
  always_comb begin
    q_next = q_r;
    if (shift_en) q_next = {q_r[LEN-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_next;
  end

  assign q = q_r;
endmodule

// File: rtl/col_ref_hold_reg.sv
module col_ref_hold_reg #(
  parameter int unsigned W = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q_r;
    if (load) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_next;
  end

  assign q = q_r;
endmodule

// File: rtl/col_ref_mux.sv
module col_ref_mux
  import col_ref_driver_pkg::*;
#(
  parameter int unsigned COLS = 1024
) (
  input  logic [COLS-1:0]   held,
  input  logic              pol_even,
  input  logic              pol_odd,
  output logic [2*COLS-1:0] sel
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    if ((c % 2) == 0) begin : g_even
      assign sel[2*c +: 2] = make_sel(pol_even, held[c]);
    end else begin : g_odd
      assign sel[2*c +: 2] = make_sel(pol_odd, held[c]);
    end
  end
endmodule

// File: rtl/col_ref_driver.sv
module col_ref_driver
  import col_ref_driver_pkg::*;
#(
  parameter int unsigned SEG_COUNT = SEG_COUNT_DEF,
  parameter int unsigned SEG_LEN   = SEG_LEN_DEF,
  localparam int unsigned COLS     = SEG_COUNT * SEG_LEN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic [SEG_COUNT-1:0] ser_in,
  input  logic                 load,
  input  logic                 pol_even,
  input  logic                 pol_odd,
  output logic [2*COLS-1:0]    col_sel
);
  logic            rst_sync_n;
  logic [COLS-1:0] shift_q;
  logic [COLS-1:0] hold_q;

  col_ref_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
    col_ref_shift_seg #(.LEN(SEG_LEN)) u_seg (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .shift_en (shift_en),
      .ser_in   (ser_in[s]),
      .q        (shift_q[s*SEG_LEN +: SEG_LEN])
    );
  end

  col_ref_hold_reg #(.W(COLS)) u_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (load),
    .d     (shift_q),
    .q     (hold_q)
  );

  col_ref_mux #(.COLS(COLS)) u_mux (
    .held     (hold_q),
    .pol_even (pol_even),
    .pol_odd  (pol_odd),
    .sel      (col_sel)
  );
endmodule

// File: rtl/col_ref_driver_chk.sv
module col_ref_driver_chk #(
  parameter int unsigned SEG_COUNT = 16,
  parameter int unsigned SEG_LEN   = 64,
  localparam int unsigned COLS     = SEG_COUNT * SEG_LEN
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 shift_en,
  input logic [SEG_COUNT-1:0] ser_in,
  input logic                 load,
  input logic                 pol_even,
  input logic                 pol_odd,
  input logic [COLS-1:0]      shift_q,
  input logic [COLS-1:0]      hold_q,
  input logic [2*COLS-1:0]    col_sel
);
  // R3: stalled edges keep the shift contents
  p_shift_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(shift_q));

  // R3: segment 0 advances by one position
  p_shift_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> shift_q[SEG_LEN-1:1] == $past(shift_q[SEG_LEN-2:0]));

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_entry
    // R2: serial line s lands at position 0 of segment s
    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> shift_q[s*SEG_LEN] == $past(ser_in[s]));
  end

  // R4: without a strobe the held row stays put
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold_q));

  // R8: strobe captures pre-shift content
  p_load_preshift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold_q == $past(shift_q));

  // R7: column 0 and column 1 polarity sources
  p_pol_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sel[1] == pol_even) && (col_sel[3] == pol_odd));

  // R6: the low code bit follows the last held bit
  p_data_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col_sel[2*COLS-2] == hold_q[COLS-1]);
endmodule

bind col_ref_driver col_ref_driver_chk #(
  .SEG_COUNT (SEG_COUNT),
  .SEG_LEN   (SEG_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .shift_en (shift_en),
  .ser_in   (ser_in),
  .load     (load),
  .pol_even (pol_even),
  .pol_odd  (pol_odd),
  .shift_q  (shift_q),
  .hold_q   (hold_q),
  .col_sel  (col_sel)
);

// File: tb/col_ref_driver_test.sv
`timescale 1ns/1ps
module col_ref_driver_test;
  localparam int SEGS = 16;
  localparam int LEN  = 64;
  localparam int COLS = SEGS * LEN;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                shift_en;
  logic [SEGS-1:0]     ser_in;
  logic                load;
  logic                pol_even;
  logic                pol_odd;
  logic [2*COLS-1:0]   col_sel;

  int vectors = 0;
  int errors  = 0;
  logic [COLS-1:0] m_sr;
  logic [COLS-1:0] m_hold;

  always #2 clk = ~clk;

  col_ref_driver uut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
    .load(load), .pol_even(pol_even), .pol_odd(pol_odd), .col_sel(col_sel)
  );

  function automatic logic [2*COLS-1:0] expect_sel();
    logic [2*COLS-1:0] e;
    for (int c = 0; c < COLS; c++)
      e[2*c +: 2] = {((c % 2) == 0) ? pol_even : pol_odd, m_hold[c]};
    return e;
  endfunction

  task automatic check_out(input string tag);
    logic [2*COLS-1:0] e;
    e = expect_sel();
    vectors++;
    if (col_sel !== e) begin
      errors++;
      for (int c = 0; c < COLS; c++) begin
        if (col_sel[2*c +: 2] !== e[2*c +: 2]) begin
          $display("FAIL %s col %0d actual %b expected %b", tag, c,
                   col_sel[2*c +: 2], e[2*c +: 2]);
          break;
        end
      end
    end
  endtask

  // One clock edge; the model mirrors the requirements (R3, R4, R8).
  task automatic step(input logic sh, input logic [SEGS-1:0] d, input logic ld);
    @(negedge clk);
    shift_en = sh; ser_in = d; load = ld;
    @(posedge clk);
    #0.5;
    if (ld) m_hold = m_sr;
    if (sh)
      for (int s = 0; s < SEGS; s++)
        m_sr[s*LEN +: LEN] = {m_sr[s*LEN +: LEN-1], d[s]};
    @(negedge clk);
    shift_en = 1'b0; load = 1'b0;
  endtask

  task automatic fill_row();
    for (int i = 0; i < LEN; i++) step(1'b1, SEGS'($urandom), 1'b0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c01d));
    rst_n = 1'b0; shift_en = 1'b0; ser_in = '0; load = 1'b0;
    pol_even = 1'b0; pol_odd = 1'b0;
    m_sr = '0; m_hold = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_out("R1 reset codes");
    pol_even = 1'b1; #0.5;
    check_out("R1 R7 reset with even polarity");
    pol_even = 1'b0;

    // R2: single marked bit in segment 5 walks to p=63 (with stalls, R3)
    step(1'b1, SEGS'(1) << 5, 1'b0);
    for (int i = 0; i < LEN-1; i++) begin
      step(1'b0, SEGS'($urandom), 1'b0);
      step(1'b1, '0, 1'b0);
    end
    step(1'b0, '0, 1'b1);
    check_out("R2 R3 marked bit");
    vectors++;
    if (col_sel[2*(5*LEN+63)] !== 1'b1 || col_sel[2*(5*LEN+62)] !== 1'b0) begin
      errors++;
      $display("FAIL R2 col 383 actual %b expected 1",
               col_sel[2*(5*LEN+63)]);
    end

    // R5 and R4: random rows, mid-row outputs stay, load shows the new row
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < LEN/2; i++) step(1'b1, SEGS'($urandom), 1'b0);
      check_out("R5 mid-row hold");
      for (int i = 0; i < LEN/2; i++) step(1'b1, SEGS'($urandom), 1'b0);
      step(1'b0, '0, 1'b1);
      check_out("R4 row loaded");
    end

    // R3: stalled cycles with toggling data, then a load
    for (int i = 0; i < 20; i++) step(1'b0, SEGS'($urandom), 1'b0);
    step(1'b0, '0, 1'b1);
    check_out("R3 stall keeps contents");

    // R3: partial row of 10 shifts
    for (int i = 0; i < 10; i++) step(1'b1, SEGS'($urandom), 1'b0);
    step(1'b0, '0, 1'b1);
    check_out("R3 partial shift");

    // R8: load together with shift, then load alone
    fill_row();
    step(1'b1, SEGS'($urandom), 1'b1);
    check_out("R8 load with shift");
    step(1'b0, '0, 1'b1);
    check_out("R8 following load");

    // R6 R7: all polarity combinations on a loaded random row
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      pol_even = p[0]; pol_odd = p[1]; #0.5;
      check_out("R6 R7 polarity sweep");
    end

    // Random mix of shifts, stalls, loads and polarity changes
    for (int i = 0; i < 3000; i++) begin
      logic sh, ld;
      sh = ($urandom % 4) != 0;
      ld = ($urandom % 40) == 0;
      if (($urandom % 50) == 0) begin
        @(negedge clk);
        pol_even = 1'($urandom); pol_odd = 1'($urandom);
      end
      step(sh, SEGS'($urandom), ld);
      if (ld || (i % 97) == 0) check_out("R4 R5 R8 random mix");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule